// File: doc/BRIEF.md
# Fault-Locating Triple-Redundant Output Voter

This block sits at the output of three redundant copies of a computing module. Instead of a bit-by-bit majority gate, it compares the copies in pairs with three full-width equality comparators. The three mismatch flags that result serve two purposes. They decide which copy drives the system output, and they identify the module or comparator that has failed, so a separate recovery controller knows what to repair.

The output path is a two-input selector that chooses between the first and second copies. It takes the second copy only when the first copy disagrees with both of the others. The flag pattern is decoded into a one-hot module location, a one-hot comparator location and an unrecoverable indication. Any raised flag also raises an error request to the controller.

The controller can drive three force inputs, one per comparator, to make that comparator report a mismatch. This lets it test the comparators for stuck outputs. In normal operation and during transient recovery the force inputs are held low. The block is purely combinational.

Top module: `tmr_locating_voter`

## Requirements
- R1: Flag `mism[2]` is high exactly when `mod_a` differs from `mod_b`. Flag `mism[1]` is high exactly when `mod_a` differs from `mod_c`. Flag `mism[0]` is high exactly when `mod_b` differs from `mod_c`. A difference in any single bit, including the most significant one, counts as a mismatch.
- R2: Each force input sets its own flag regardless of the data. `force_ab` sets `mism[2]`, `force_ac` sets `mism[1]` and `force_bc` sets `mism[0]`.
- R3: `vote_out` equals `mod_b` when `mism[2]` and `mism[1]` are both high. Otherwise it equals `mod_a`. This also holds for the unrecoverable pattern 111.
- R4: A mismatch pattern that points to a single module sets one bit of `fault_mod`. Pattern 110 sets bit 0 (first copy), pattern 101 sets bit 1 (second copy) and pattern 011 sets bit 2 (third copy). In each case `vote_out` equals a copy that is not faulty.
- R5: A pattern with exactly one flag set reports a comparator fault in `cmp_fault` and leaves `fault_mod` at zero. Pattern 100 sets bit 0 (the first/second comparator), 010 sets bit 1 (the first/third comparator) and 001 sets bit 2 (the second/third comparator).
- R6: Pattern 111 sets `unrecov` and leaves `fault_mod` and `cmp_fault` at zero. No other pattern sets `unrecov`.
- R7: `err_req` is high exactly when at least one mismatch flag is high.
- R8: When all three copies agree and no force input is high, all flags and location codes are zero, `err_req` is low and `vote_out` equals `mod_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mod_a | input | W | Output of the first redundant copy |
| mod_b | input | W | Output of the second redundant copy |
| mod_c | input | W | Output of the third redundant copy |
| force_ab | input | 1 | Force a mismatch on the first/second comparator |
| force_ac | input | 1 | Force a mismatch on the first/third comparator |
| force_bc | input | 1 | Force a mismatch on the second/third comparator |
| vote_out | output | W | Selected error-free output |
| mism | output | 3 | Mismatch flags {a/b, a/c, b/c} |
| fault_mod | output | 3 | One-hot faulty copy {third, second, first} |
| cmp_fault | output | 3 | One-hot faulty comparator {b/c, a/c, a/b} |
| unrecov | output | 1 | All three flags set; no copy can be trusted |
| err_req | output | 1 | Request to the recovery controller |

## Verification
The bench injects corruption into each copy on random data and checks that the output follows a healthy copy. A selector wired to the wrong flag would pass a corrupted value through. A corruption limited to the top bit would catch a comparator that is one bit too narrow. Two copies corrupted differently must give the unrecoverable pattern. Two copies corrupted identically outvote the good copy, and the bench expects the block to blame the first copy. Each force input is driven alone over agreeing data, which must yield a comparator location and a clean first-copy output; swapped force wiring or a decoder that mistakes a single flag for a module fault would show up there.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

  // Flag vector layout: bit 2 = a/b, bit 1 = a/c, bit 0 = b/c.
  localparam int NUM_COPIES = 3;
  localparam int NUM_PAIRS  = 3;

  typedef struct packed {
    logic [2:0] fault_mod;  // bit0 first copy, bit1 second, bit2 third
    logic [2:0] cmp_fault;  // bit0 a/b, bit1 a/c, bit2 b/c
    logic       unrecov;
  } loc_t;

  // Lower-numbered copy of pair k (k=0: a/b, 1: a/c, 2: b/c).
  function automatic int pair_lo(input int k);
    return (k == 2) ? 1 : 0;
  endfunction

  function automatic int pair_hi(input int k);
    return (k == 0) ? 1 : 2;
  endfunction

  // Position of pair k inside the flag vector.
  function automatic int flag_pos(input int k);
    return 2 - k;
  endfunction

  // Second copy is taken only when the first disagrees with both others.
  function automatic logic pick_second(input logic [2:0] flags);
    return flags[2] & flags[1];
  endfunction

  function automatic loc_t decode_flags(input logic [2:0] flags);
    loc_t r;
    r = '0;
    unique case (flags)
      3'b000: r = '0;
      3'b001: r.cmp_fault = 3'b100;
      3'b010: r.cmp_fault = 3'b010;
      3'b100: r.cmp_fault = 3'b001;
      3'b011: r.fault_mod = 3'b100;
      3'b101: r.fault_mod = 3'b010;
      3'b110: r.fault_mod = 3'b001;
      3'b111: r.unrecov   = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_pair_cmp.sv
module tmr_pair_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         force_mis,
  output logic         mis
);
  logic [W-1:0] diff_bits;
  logic         data_differ;

  always_comb begin
    diff_bits   = lhs ^ rhs;
    data_differ = |diff_bits;
    mis         = data_differ | force_mis;
  end
endmodule

// File: rtl/tmr_fault_decode.sv
module tmr_fault_decode
  import tmr_vote_pkg::*;
(
  input  logic [2:0] flags,
  output logic [2:0] fault_mod,
  output logic [2:0] cmp_fault,
  output logic       unrecov,
  output logic       err_req
);
  loc_t loc;

  always_comb begin
    loc       = decode_flags(flags);
    fault_mod = loc.fault_mod;
    cmp_fault = loc.cmp_fault;
    unrecov   = loc.unrecov;
    err_req   = |flags;
  end
endmodule

// File: rtl/tmr_out_select.sv
module tmr_out_select
  import tmr_vote_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] first_in,
  input  logic [W-1:0] second_in,
  input  logic [2:0]   flags,
  output logic         take_second,
  output logic [W-1:0] sel_out
);
  always_comb begin
    take_second = pick_second(flags);
    sel_out     = take_second ? second_in : first_in;
  end
endmodule

// File: rtl/tmr_locating_voter.sv
module tmr_locating_voter
  import tmr_vote_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] mod_a,
  input  logic [W-1:0] mod_b,
  input  logic [W-1:0] mod_c,
  input  logic         force_ab,
  input  logic         force_ac,
  input  logic         force_bc,
  output logic [W-1:0] vote_out,
  output logic [2:0]   mism,
  output logic [2:0]   fault_mod,
  output logic [2:0]   cmp_fault,
  output logic         unrecov,
  output logic         err_req
);
  logic [W-1:0] copies [NUM_COPIES];
  logic [2:0]   forces_by_pair;
  logic [2:0]   flags;
  logic         take_second;

  always_comb begin
    copies[0] = mod_a;
    copies[1] = mod_b;
    copies[2] = mod_c;
    forces_by_pair = {force_bc, force_ac, force_ab};
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    tmr_pair_cmp #(.W(W)) u_cmp (
      .lhs      (copies[pair_lo(k)]),
      .rhs      (copies[pair_hi(k)]),
      .force_mis(forces_by_pair[k]),
      .mis      (flags[flag_pos(k)])
    );
  end

  tmr_out_select #(.W(W)) u_sel (
    .first_in   (mod_a),
    .second_in  (mod_b),
    .flags      (flags),
    .take_second(take_second),
    .sel_out    (vote_out)
  );

  tmr_fault_decode u_dec (
    .flags    (flags),
    .fault_mod(fault_mod),
    .cmp_fault(cmp_fault),
    .unrecov  (unrecov),
    .err_req  (err_req)
  );

  assign mism = flags;
endmodule

// File: rtl/tmr_locating_voter_chk.sv
module tmr_locating_voter_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] mod_a,
  input logic [W-1:0] mod_b,
  input logic [W-1:0] mod_c,
  input logic         force_ab,
  input logic         force_ac,
  input logic         force_bc,
  input logic [W-1:0] vote_out,
  input logic [2:0]   mism,
  input logic [2:0]   fault_mod,
  input logic [2:0]   cmp_fault,
  input logic         unrecov,
  input logic         err_req,
  input logic         take_second
);
  always_comb begin
    if (!mism[2]) p_clear_ab_r1: assert (mod_a == mod_b);
    if (!mism[0]) p_clear_bc_r1: assert (mod_b == mod_c);
    if (force_ac) p_force_ac_r2: assert (mism[1]);
    if (take_second) p_sel_b_r3: assert (vote_out == mod_b);
    else             p_sel_a_r3: assert (vote_out == mod_a);
    if (fault_mod[0]) p_first_bad_r4: assert (mod_b == mod_c || force_bc);
    p_loc_onehot_r4: assert ($onehot0(fault_mod) && $onehot0(cmp_fault));
    if (cmp_fault != 3'b000) p_cmp_excl_r5: assert (fault_mod == 3'b000 && $countones(mism) == 1);
    if (unrecov) p_unrec_r6: assert (mism == 3'b111 && fault_mod == 3'b000);
    p_err_r7: assert (err_req == (mism != 3'b000));
  end
endmodule

bind tmr_locating_voter tmr_locating_voter_chk #(.W(W)) u_chk (
  .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
  .force_ab(force_ab), .force_ac(force_ac), .force_bc(force_bc),
  .vote_out(vote_out), .mism(mism), .fault_mod(fault_mod),
  .cmp_fault(cmp_fault), .unrecov(unrecov), .err_req(err_req),
  .take_second(take_second)
);

// File: tb/sim_tmr_locating_voter.sv
`timescale 1ns/1ps
module sim_tmr_locating_voter;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] out;
    logic [2:0]   flags;
    logic [2:0]   fmod;
    logic [2:0]   fcmp;
    logic         unrec;
    logic         req;
    string        tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, c;
  logic fab, fac, fbc;
  logic [W-1:0] vout;
  logic [2:0] mism, fmod, fcmp;
  logic unrec, req;

  int checks = 0, fails = 0;
  int cycles = 0;
  bit done = 0;
  exp_t q[$];

  tmr_locating_voter #(.W(W)) u0 (
    .mod_a(a), .mod_b(b), .mod_c(c),
    .force_ab(fab), .force_ac(fac), .force_bc(fbc),
    .vote_out(vout), .mism(mism), .fault_mod(fmod), .cmp_fault(fcmp),
    .unrecov(unrec), .err_req(req)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies stimulus and queues the model's expectation.
  task automatic drive(input string tag, input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [W-1:0] xc, input logic f1, input logic f2, input logic f3);
    exp_t e;
    logic e12, e13, e23;
    @(negedge clk);
    a = xa; b = xb; c = xc; fab = f1; fac = f2; fbc = f3;
    e12 = (xa != xb) || f1;
    e13 = (xa != xc) || f2;
    e23 = (xb != xc) || f3;
    e.flags = {e12, e13, e23};
    e.out   = (e12 && e13) ? xb : xa;
    e.fmod  = 3'b000; e.fcmp = 3'b000; e.unrec = 1'b0;
    if (e12 && e13 && e23) e.unrec = 1'b1;
    else if (e12 && e13)   e.fmod = 3'b001;
    else if (e12 && e23)   e.fmod = 3'b010;
    else if (e13 && e23)   e.fmod = 3'b100;
    else if (e12)          e.fcmp = 3'b001;
    else if (e13)          e.fcmp = 3'b010;
    else if (e23)          e.fcmp = 3'b100;
    e.req = e12 || e13 || e23;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares half a cycle after the stimulus.
  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " R1 R2 flags"}, W'(mism), W'(e.flags));
      chk({e.tag, " R3 R4 vote_out"}, vout, e.out);
      chk({e.tag, " R4 fault_mod"}, W'(fmod), W'(e.fmod));
      chk({e.tag, " R5 cmp_fault"}, W'(fcmp), W'(e.fcmp));
      chk({e.tag, " R6 unrecov"}, W'(unrec), W'(e.unrec));
      chk({e.tag, " R7 err_req"}, W'(req), W'(e.req));
    end
  end

  function automatic logic [W-1:0] nz_mask();
    logic [W-1:0] m;
    m = $urandom();
    if (m == '0) m = 1;
    return m;
  endfunction

  initial begin
    a = '0; b = '0; c = '0; fab = 0; fac = 0; fbc = 0;
    repeat (2) @(posedge clk);
    rst = 0;
    drive("R8 idle zero", '0, '0, '0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] d, m, m2;
      d = $urandom(); m = nz_mask(); m2 = nz_mask();
      if (m2 == m) m2 = m ^ 1;
      drive("R8 agree", d, d, d, 0, 0, 0);
      drive("R4 first bad", d ^ m, d, d, 0, 0, 0);
      drive("R4 second bad", d, d ^ m, d, 0, 0, 0);
      drive("R4 third bad", d, d, d ^ m, 0, 0, 0);
      drive("R6 two differ", d, d ^ m, d ^ m2, 0, 0, 0);
      drive("R4 two same", d, d ^ m, d ^ m, 0, 0, 0);
      drive("R5 R2 force ab", d, d, d, 1, 0, 0);
      drive("R5 R2 force ac", d, d, d, 0, 1, 0);
      drive("R5 R2 force bc", d, d, d, 0, 0, 1);
      drive("R2 force on fault", d, d ^ m, d, 0, 0, 1);
    end
    drive("R1 msb only a", {1'b1, {(W-1){1'b0}}}, '0, '0, 0, 0, 0);
    drive("R1 msb only c", '1, '1, {1'b0, {(W-1){1'b1}}}, 0, 0, 0);
    drive("R6 all forced", 32'h5a5a_0f0f, 32'h5a5a_0f0f, 32'h5a5a_0f0f, 1, 1, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule